// File: doc/BRIEF.md
# Peripheral Status Flag and Clear Sequencer

This block holds one peripheral's interrupt status flags and produces that peripheral's request line to the interrupt controller. Hardware event strobes set the flags. A flag asks for service only while its enable bit from the control register is set and the global interrupt mask is clear. Otherwise the flag simply stays latched and the request waits.

Software clears a flag in either of two ways. It can write 0 to that flag's bit in the status register. It can also use a two-step sequence: first any access (read or write) to the status register, which arms every flag that is set at that moment, then any read or write of the peripheral's data register, which clears the armed flags. Because clearing drops the latch itself, a request that was waiting to be unmasked is lost for good. The peripheral's data path is not part of this block.

Top module: `psf_status_unit`

## Requirements
- R1: A 1 on `evt_set[i]` sets flag i at the next clock edge. A read of the status register (address `STAT_ADDR`, default 0) returns flag i on `rd_data[i]` in the same cycle as `bus_rd`.
- R2: `irq_req` is 1 exactly when `irq_mask` is 0 and at least one flag is set whose `irq_en` bit is 1. A flag whose request is blocked by either condition stays set, and it raises `irq_req` as soon as both conditions are met.
- R3: A write to the status register clears every flag whose `bus_wdata` bit is 0. Flags whose written bit is 1 keep their value.
- R4: Any access to the status register arms the flags that are set in that cycle. The next read or write of the data register (address `DATA_ADDR`, default 1) clears every armed flag and disarms all flags.
- R5: A data-register access clears no flag that was not armed, whether the flag was set after the status access or no status access came first.
- R6: Reads or writes to addresses other than the status and data registers neither clear flags nor cancel armed flags, and they return 0 on `rd_data`.
- R7: An event strobe in the same cycle as a clear of the same flag, by either method, leaves the flag set.
- R8: Once a flag is cleared while its request is masked, it raises no request when the mask is later lifted.
- R9: Reset clears all flags and all armed state. `rd_data` is 0 in every cycle without a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | NFLAG | Hardware event strobes, one per flag |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NFLAG | Write data |
| irq_en | input | NFLAG | Per-flag enable bits from the control register |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks requests |
| irq_req | output | 1 | Request to the interrupt controller |
| rd_data | output | NFLAG | Read data; status flags on a status read, otherwise 0 |

## Verification
An armed bit that is wrong never appears on a status read. It shows only one cycle after a data-register access, as a flag that clears when it should stay set or stays set when it should clear. The bench therefore reads the status register again after each sequence step. A flag stuck at 1 or 0 shows on `rd_data` at the next status read, and on `irq_req` in the first cycle where its enable is set and the mask is clear. A clear that leaves a latched request behind shows only when the mask is lifted, so the bench clears flags while they are masked and then unmasks them.

// File: rtl/psf_pkg.sv
package psf_pkg;

  // Next value of one flag: a set strobe beats any clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Next value of one armed bit.
  function automatic logic arm_next(input logic cur_arm, input logic cur_flag,
                                    input logic stat_acc, input logic data_acc,
                                    input logic wr_clr);
    if (data_acc) return 1'b0;
    return (cur_arm | (stat_acc & cur_flag)) & ~wr_clr;
  endfunction

  // Clear condition of one flag in this cycle.
  function automatic logic clr_now(input logic cur_arm, input logic data_acc,
                                   input logic wr_clr);
    return wr_clr | (data_acc & cur_arm);
  endfunction

endpackage

// File: rtl/psf_decode.sv
module psf_decode #(
  parameter int NFLAG     = 4,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [NFLAG-1:0]  bus_wdata,
  output logic              stat_acc,
  output logic              stat_rd,
  output logic              data_acc,
  output logic              other_acc,
  output logic [NFLAG-1:0]  wr_clr
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  logic any_acc, hit_stat, hit_data;

  always_comb begin
    any_acc   = bus_rd | bus_wr;
    hit_stat  = (bus_addr == STAT_A);
    hit_data  = (bus_addr == DATA_A);
    stat_acc  = any_acc & hit_stat;
    stat_rd   = bus_rd & hit_stat;
    data_acc  = any_acc & hit_data;
    other_acc = any_acc & ~hit_stat & ~hit_data;
    wr_clr    = (bus_wr & hit_stat) ? ~bus_wdata : '0;
  end
endmodule

// File: rtl/psf_flag_bank.sv
module psf_flag_bank
  import psf_pkg::*;
#(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_set,
  input  logic             stat_acc,
  input  logic             data_acc,
  input  logic [NFLAG-1:0] wr_clr,
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] arm_q,
  output logic [NFLAG-1:0] clr_hit
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    logic clr_i;
    always_comb clr_i = clr_now(arm_q[i], data_acc, wr_clr[i]);
    assign clr_hit[i] = clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
        arm_q[i]   <= 1'b0;
      end else begin
        flags_q[i] <= flag_next(flags_q[i], evt_set[i], clr_i);
        arm_q[i]   <= arm_next(arm_q[i], flags_q[i], stat_acc, data_acc, wr_clr[i]);
      end
    end
  end
endmodule

// File: rtl/psf_req.sv
module psf_req #(
  parameter int NFLAG = 4
) (
  input  logic [NFLAG-1:0] flags_q,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             irq_mask,
  output logic             irq_req
);
  logic [NFLAG-1:0] live;
  always_comb begin
    live    = flags_q & irq_en;
    irq_req = ~irq_mask & (|live);
  end
endmodule

// File: rtl/psf_status_unit.sv
module psf_status_unit #(
  parameter int NFLAG     = 4,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  evt_set,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [NFLAG-1:0]  bus_wdata,
  input  logic [NFLAG-1:0]  irq_en,
  input  logic              irq_mask,
  output logic              irq_req,
  output logic [NFLAG-1:0]  rd_data
);
  logic             stat_acc, stat_rd, data_acc, other_acc;
  logic [NFLAG-1:0] wr_clr, flags_q, arm_q, clr_hit;

  psf_decode #(
    .NFLAG(NFLAG), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) dec_i (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .stat_acc(stat_acc), .stat_rd(stat_rd), .data_acc(data_acc),
    .other_acc(other_acc), .wr_clr(wr_clr)
  );

  psf_flag_bank #(.NFLAG(NFLAG)) bank_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .stat_acc(stat_acc), .data_acc(data_acc), .wr_clr(wr_clr),
    .flags_q(flags_q), .arm_q(arm_q), .clr_hit(clr_hit)
  );

  psf_req #(.NFLAG(NFLAG)) req_i (
    .flags_q(flags_q), .irq_en(irq_en), .irq_mask(irq_mask), .irq_req(irq_req)
  );

  assign rd_data = stat_rd ? flags_q : '0;
endmodule

// File: rtl/psf_status_chk.sv
module psf_status_chk #(
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] evt_set,
  input logic [NFLAG-1:0] bus_wdata,
  input logic             stat_acc,
  input logic             stat_rd,
  input logic             data_acc,
  input logic             other_acc,
  input logic             bus_wr,
  input logic [NFLAG-1:0] flags_q,
  input logic [NFLAG-1:0] arm_q,
  input logic [NFLAG-1:0] clr_hit,
  input logic             irq_mask,
  input logic             irq_req,
  input logic [NFLAG-1:0] rd_data
);
  // R1 and R7: a strobed flag is set after the edge, whatever clear came with it
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flags_q & $past(evt_set)) == $past(evt_set)));

  // R2: a masked block never requests
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq_req);

  // R3: bits written as 1 keep their flags
  a_r3_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_acc && bus_wr) |=> ((flags_q & $past(flags_q & bus_wdata)) == $past(flags_q & bus_wdata)));

  // R4: armed flags without a fresh event are gone after a data access
  a_r4_data_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ((flags_q & $past(arm_q & ~evt_set)) == '0));

  // R4: nothing stays armed after a data access
  a_r4_disarm_all: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (arm_q == '0));

  // R5: an armed bit never stands for a cleared flag
  a_r5_arm_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q & ~flags_q) == '0);

  // R5: unarmed flags survive a data access
  a_r5_unarmed_kept: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ((flags_q & $past(flags_q & ~arm_q)) == $past(flags_q & ~arm_q)));

  // R6: foreign accesses leave armed state and flags alone
  a_r6_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (other_acc && evt_set == '0) |=> (arm_q == $past(arm_q) && flags_q == $past(flags_q)));

  // R6 and R9: no status read, no read data
  a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |-> (rd_data == '0));

  // R8: a cleared flag carries no leftover request
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_hit) && ((clr_hit & evt_set) == '0)) |=> ((flags_q & $past(clr_hit)) == '0));
endmodule

bind psf_status_unit psf_status_chk #(.NFLAG(NFLAG)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_wdata(bus_wdata),
  .stat_acc(stat_acc), .stat_rd(stat_rd), .data_acc(data_acc),
  .other_acc(other_acc), .bus_wr(bus_wr), .flags_q(flags_q), .arm_q(arm_q),
  .clr_hit(clr_hit), .irq_mask(irq_mask), .irq_req(irq_req), .rd_data(rd_data)
);

// File: tb/psf_status_unit_tb.sv
module psf_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int NVEC = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] evt_set = '0;
  logic [1:0]    bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [NF-1:0] bus_wdata = '0;
  logic [NF-1:0] irq_en = '0;
  logic          irq_mask = 1'b0;
  logic          irq_req;
  logic [NF-1:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psf_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_en(irq_en),
    .irq_mask(irq_mask), .irq_req(irq_req), .rd_data(rd_data)
  );

  // Row: {evt, addr, rd, wr, wdata, en, mask, exp_irq, exp_rd}
  // Status register at address 0, data register at 1, others foreign.
  // Expected values hold in the row's own cycle, before its clock edge.
  localparam logic [21:0] VEC [NVEC] = '{
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000}, // R9 empty
    {4'b0011, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000}, // R1 set two
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0001, 1'b1, 1'b0, 4'b0011}, // R1 R2 R4 arm
    {4'b0100, 2'd2, 1'b1, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b1, 4'b0000}, // R6 foreign rd
    {4'b0000, 2'd1, 1'b1, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b1, 4'b0000}, // R4 data rd
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0100, 1'b0, 1'b1, 4'b0100}, // R4 R5 check
    {4'b0100, 2'd1, 1'b0, 1'b1, 4'b0000, 4'b0100, 1'b0, 1'b1, 4'b0000}, // R7 set wins
    {4'b0000, 2'd1, 1'b1, 1'b0, 4'b0000, 4'b0100, 1'b0, 1'b1, 4'b0000}, // R5 no arm
    {4'b0000, 2'd0, 1'b0, 1'b1, 4'b1111, 4'b0100, 1'b0, 1'b1, 4'b0000}, // R3 write ones
    {4'b0000, 2'd0, 1'b0, 1'b1, 4'b1011, 4'b0100, 1'b0, 1'b1, 4'b0000}, // R3 write zero
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0100, 1'b0, 1'b0, 4'b0000}, // R3 gone
    {4'b1000, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b1000, 1'b1, 1'b0, 4'b0000}, // R2 masked
    {4'b0000, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b1000, 1'b1, 1'b0, 4'b0000}, // R2 pending
    {4'b0001, 2'd0, 1'b0, 1'b1, 4'b0000, 4'b1001, 1'b1, 1'b0, 4'b0000}, // R7 R3 clear
    {4'b0000, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b1000, 1'b0, 1'b0, 4'b0000}, // R8 lost
    {4'b0000, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b1, 4'b0000}, // R7 kept
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b1, 4'b0001}, // R4 arm b0
    {4'b0010, 2'd3, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000}, // R6 R5 late set
    {4'b0000, 2'd1, 1'b0, 1'b1, 4'b0000, 4'b0010, 1'b0, 1'b1, 4'b0000}, // R4 data wr
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0011, 1'b0, 1'b1, 4'b0010}, // R5 late kept
    {4'b0000, 2'd1, 1'b1, 1'b0, 4'b0000, 4'b0010, 1'b0, 1'b1, 4'b0000}, // R4 clear b1
    {4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 1'b0, 4'b0000}  // R4 empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [NF-1:0] ev, input logic [1:0] a, input logic r,
                       input logic w, input logic [NF-1:0] wd, input logic [NF-1:0] en,
                       input logic m);
    @(negedge clk);
    evt_set = ev; bus_addr = a; bus_rd = r; bus_wr = w;
    bus_wdata = wd; irq_en = en; irq_mask = m;
    #1;
  endtask

  task automatic idle();
    drive('0, 2'd2, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    drive('0, 2'd0, 1'b1, 1'b0, '0, 4'b1111, 1'b0);
    chk("R9 reset rd", rd_data, '0);
    chk("R9 reset irq", irq_req, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][21:18], VEC[k][17:16], VEC[k][15], VEC[k][14], VEC[k][13:10],
            VEC[k][9:6], VEC[k][5]);
      chk($sformatf("R1-table row %0d irq", k), irq_req, VEC[k][4]);
      chk($sformatf("R1-table row %0d rd", k), rd_data, VEC[k][3:0]);
    end

    // R8: sequence clear while masked drops the request
    drive(4'b0010, 2'd2, 1'b0, 1'b0, '0, 4'b0010, 1'b1);
    drive('0, 2'd0, 1'b1, 1'b0, '0, 4'b0010, 1'b1);
    chk("R8 masked pending rd", rd_data, 4'b0010);
    chk("R8 masked no irq", irq_req, 1'b0);
    drive('0, 2'd1, 1'b1, 1'b0, '0, 4'b0010, 1'b1);
    drive('0, 2'd2, 1'b0, 1'b0, '0, 4'b0010, 1'b0);
    chk("R8 unmasked after clear", irq_req, 1'b0);

    // R2: masked pending request appears once unmasked
    drive(4'b1000, 2'd2, 1'b0, 1'b0, '0, 4'b1000, 1'b1);
    drive('0, 2'd2, 1'b0, 1'b0, '0, 4'b1000, 1'b1);
    chk("R2 still masked", irq_req, 1'b0);
    drive('0, 2'd2, 1'b0, 1'b0, '0, 4'b1000, 1'b0);
    chk("R2 unmask raises", irq_req, 1'b1);

    // R9: reset in mid-run wipes flags and armed state
    drive(4'b1111, 2'd2, 1'b0, 1'b0, '0, '0, 1'b1);
    drive('0, 2'd0, 1'b1, 1'b0, '0, '0, 1'b1);
    chk("R1 all set", rd_data, 4'b1111);
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    drive(4'b0001, 2'd2, 1'b0, 1'b0, '0, '0, 1'b1);
    drive('0, 2'd1, 1'b1, 1'b0, '0, '0, 1'b1);
    drive('0, 2'd0, 1'b1, 1'b0, '0, 4'b1111, 1'b0);
    chk("R9 after reset rd", rd_data, 4'b0001);
    chk("R9 after reset irq", irq_req, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule